// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block keeps one sticky request flag for each interrupt cause of a small controller and turns those flags into one request line per interrupt source for the priority unit that follows. Two pins are active-low external inputs, and each can work in edge mode or in level mode. Three more pins are active-high external inputs. Each of the three high pins shares its flag with a compare-match pulse. Two timer events share one request line. A conversion-done pulse has a request line of its own.

Every pin passes through a synchronizer. After that, a small two-state edge machine watches each pin. The machine has two states, `EDGE_LOW` and `EDGE_HIGH`, which record the last sampled level. The `EDGE_LOW -> EDGE_HIGH` transition is a rise. The `EDGE_HIGH -> EDGE_LOW` transition is a fall. A machine raises its one-cycle edge pulse only on the transition it is built to detect. The flags update on a fixed order of precedence: a forced clear first, then a hardware set, then a software write, then an acknowledge clear. The CPU reads and writes all eight flags as one byte. The vector logic returns a one-cycle acknowledge that carries a source index.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, `rd_data` and `req` are all zero.
- R2: Flag bits are laid out as follows. Bit 0 is external 0 and bit 1 is external 1. Bit 2 is timer overflow and bit 3 is timer external. Bit 4 is conversion done. Bits 5 to 7 are high pins 0 to 2. The request index is 0 for external 0 and 1 for external 1. Index 2 is the OR of bits 2 and 3. Index 3 is bit 4. Indices 4 to 6 are bits 5 to 7.
- R3: An acknowledge never clears the timer flags (bits 2 and 3) or the conversion flag (bit 4). These flags clear only through a software write.
- R4: Each `adc_done_evt` pulse sets bit 4, including a pulse that arrives after software has cleared the bit.
- R5: A low-to-high transition on `pin_hi[j]`, after a two-flop synchronizer, sets bit 5+j. A high-to-low transition has no effect on the flag.
- R6: A `cmp_evt[j]` pulse sets bit 5+j, whatever the level or motion of `pin_hi[j]`.
- R7: An acknowledge (`ack_valid` with `ack_src`=s) clears only one flag. For s=0 or s=1 it clears bit s, and only in edge mode. For s=4, 5 or 6 it clears bit s+1. For any other index it clears nothing.
- R8: A write with `wr_en` loads `wr_data` into every flag that is in edge mode or is an event flag, so software can raise or cancel a request.
- R9: When `mode_edge[i]`=0 (level mode), bit i reads as the inverse of the synchronized `pin_ext[i]`. A write of one does not set it, and an acknowledge does not clear it.
- R10: When `mode_edge[i]`=1 (edge mode), a falling transition on `pin_ext[i]` sets bit i and a rising transition does not.
- R11: When a hardware set and a software write of zero reach the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_ext | input | 2 | Active-low external pins 0 and 1 |
| mode_edge | input | 2 | 1 = edge mode, 0 = level mode, per low pin |
| pin_hi | input | 3 | Rising-edge external pins |
| cmp_evt | input | 3 | Compare-match pulses sharing the high pin flags |
| t2_ovf_evt | input | 1 | Timer overflow pulse |
| t2_ext_evt | input | 1 | Timer external reload/capture pulse |
| adc_done_evt | input | 1 | Conversion complete pulse |
| ack_valid | input | 1 | One-cycle vector acknowledge |
| ack_src | input | 3 | Request index being acknowledged |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 8 | Software write value for all flags |
| rd_data | output | 8 | Current flag values |
| req | output | 7 | Request lines to the priority unit |

## Verification
The assertions check four properties on every cycle. A hardware set always lands in the flag. An edge pulse never lasts two cycles. The timer and conversion flags survive acknowledges. An acknowledge of high pin 0 leaves its flag clear.

Some behaviours show only in the bench's scenarios. These are the full write/readback sweep, the acknowledge sweep over every index, the synchronizer latency of the pin paths, and level-mode tracking against writes.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int NUM_LO   = 2;
    localparam int NUM_HI   = 3;
    localparam int IDX_T2O  = NUM_LO;
    localparam int IDX_T2E  = NUM_LO + 1;
    localparam int IDX_ADC  = NUM_LO + 2;
    localparam int IDX_HI0  = NUM_LO + 3;
    localparam int FLAG_W   = IDX_HI0 + NUM_HI;
    localparam int REQ_W    = FLAG_W - 1;
    localparam int REQ_T2   = NUM_LO;
    localparam int REQ_ADC  = NUM_LO + 1;
    localparam int REQ_HI0  = NUM_LO + 2;
    localparam int ACK_W    = $clog2(REQ_W);

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   WIDTH   = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{{WIDTH{RST_VAL}}}};
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_flag_pkg::*;
#(
    parameter logic RISING    = 1'b1,
    parameter logic RST_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic edge_pulse
);
    edge_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            EDGE_LOW:  if (level)  state_nx = EDGE_HIGH;
            EDGE_HIGH: if (!level) state_nx = EDGE_LOW;
            default:   state_nx = EDGE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RST_LEVEL ? EDGE_HIGH : EDGE_LOW;
        else        state <= state_nx;
    end

    always_comb begin
        edge_pulse = 1'b0;
        unique case (state)
            EDGE_LOW:  edge_pulse = RISING && level;
            EDGE_HIGH: edge_pulse = !RISING && !level;
            default:   edge_pulse = 1'b0;
        endcase
    end

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> !edge_pulse)
        else $error("edge pulse lasted two cycles");
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic force_clr,
    input  logic hw_set,
    input  logic sw_we,
    input  logic sw_val,
    input  logic ack_clr,
    output logic q
);
    logic q_nx;

    always_comb begin
        if (force_clr)   q_nx = 1'b0;
        else if (hw_set) q_nx = 1'b1;
        else if (sw_we)  q_nx = sw_val;
        else if (ack_clr) q_nx = 1'b0;
        else             q_nx = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_nx;
    end

    assert_hw_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set && !force_clr) |=> q)
        else $error("hardware set lost");
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_flag_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LO-1:0] pin_ext,
    input  logic [NUM_LO-1:0] mode_edge,
    input  logic [NUM_HI-1:0] pin_hi,
    input  logic [NUM_HI-1:0] cmp_evt,
    input  logic              t2_ovf_evt,
    input  logic              t2_ext_evt,
    input  logic              adc_done_evt,
    input  logic              ack_valid,
    input  logic [ACK_W-1:0]  ack_src,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_data,
    output logic [FLAG_W-1:0] rd_data,
    output logic [REQ_W-1:0]  req
);
    logic [NUM_LO-1:0] lo_sync, lo_edge;
    logic [NUM_HI-1:0] hi_sync, hi_edge;
    logic [FLAG_W-1:0] hw_set, ack_clr, force_clr, sw_we, flag_q;
    logic [REQ_W-1:0]  ack_hit;

    irq_sync #(.WIDTH(NUM_LO), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lo (
        .clk(clk), .rst_n(rst_n), .d(pin_ext), .q(lo_sync));
    irq_sync #(.WIDTH(NUM_HI), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hi (
        .clk(clk), .rst_n(rst_n), .d(pin_hi), .q(hi_sync));

    for (genvar r = 0; r < REQ_W; r++) begin : g_ack
        assign ack_hit[r] = ack_valid && (ack_src == ACK_W'(r));
    end

    for (genvar i = 0; i < NUM_LO; i++) begin : g_lo
        irq_edge_fsm #(.RISING(1'b0), .RST_LEVEL(1'b1)) u_edge (
            .clk(clk), .rst_n(rst_n), .level(lo_sync[i]), .edge_pulse(lo_edge[i]));
        assign hw_set[i]    = mode_edge[i] && lo_edge[i];
        assign force_clr[i] = !mode_edge[i];
        assign sw_we[i]     = wr_en && mode_edge[i];
        assign ack_clr[i]   = ack_hit[i] && mode_edge[i];
        assign rd_data[i]   = mode_edge[i] ? flag_q[i] : !lo_sync[i];
        assign req[i]       = rd_data[i];
    end

    assign hw_set[IDX_T2O] = t2_ovf_evt;
    assign hw_set[IDX_T2E] = t2_ext_evt;
    assign hw_set[IDX_ADC] = adc_done_evt;
    for (genvar k = IDX_T2O; k <= IDX_ADC; k++) begin : g_evt
        assign force_clr[k] = 1'b0;
        assign sw_we[k]     = wr_en;
        assign ack_clr[k]   = 1'b0;
        assign rd_data[k]   = flag_q[k];
    end
    assign req[REQ_T2]  = flag_q[IDX_T2O] | flag_q[IDX_T2E];
    assign req[REQ_ADC] = flag_q[IDX_ADC];

    for (genvar j = 0; j < NUM_HI; j++) begin : g_hi
        irq_edge_fsm #(.RISING(1'b1), .RST_LEVEL(1'b0)) u_edge (
            .clk(clk), .rst_n(rst_n), .level(hi_sync[j]), .edge_pulse(hi_edge[j]));
        assign hw_set[IDX_HI0+j]    = hi_edge[j] | cmp_evt[j];
        assign force_clr[IDX_HI0+j] = 1'b0;
        assign sw_we[IDX_HI0+j]     = wr_en;
        assign ack_clr[IDX_HI0+j]   = ack_hit[REQ_HI0+j];
        assign rd_data[IDX_HI0+j]   = flag_q[IDX_HI0+j];
        assign req[REQ_HI0+j]       = flag_q[IDX_HI0+j];
    end

    for (genvar f = 0; f < FLAG_W; f++) begin : g_cell
        irq_flag_cell u_cell (
            .clk(clk), .rst_n(rst_n), .force_clr(force_clr[f]), .hw_set(hw_set[f]),
            .sw_we(sw_we[f]), .sw_val(wr_data[f]), .ack_clr(ack_clr[f]), .q(flag_q[f]));
    end

    assert_ack_keeps_timer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !wr_en && !t2_ovf_evt && !t2_ext_evt)
        |=> $stable(rd_data[IDX_T2E:IDX_T2O]))
        else $error("timer flags changed on acknowledge");

    assert_adc_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[IDX_ADC] && !wr_en) |=> rd_data[IDX_ADC])
        else $error("conversion flag cleared without write");

    assert_ack_clears_hi0_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_src == ACK_W'(REQ_HI0) && !wr_en && !hi_edge[0] && !cmp_evt[0])
        |=> !rd_data[IDX_HI0])
        else $error("acknowledge did not clear high pin flag");
endmodule

// File: tb/sim_irq_flag_reg.sv
module sim_irq_flag_reg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_ext = 2'b11;
    logic [1:0] mode_edge = 2'b11;
    logic [2:0] pin_hi = 3'b000;
    logic [2:0] cmp_evt = 3'b000;
    logic       t2_ovf_evt = 1'b0, t2_ext_evt = 1'b0, adc_done_evt = 1'b0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_src = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic [6:0] req;
    int         n_vec = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    irq_flag_reg u0 (.*);

    function automatic logic [6:0] exp_req(input logic [7:0] v);
        return {v[7:5], v[4], v[3] | v[2], v[1], v[0]};
    endfunction

    function automatic logic [7:0] ack_mask(input int s);
        if (s < 2) return 8'(1 << s);
        if (s >= 4 && s <= 6) return 8'(1 << (s + 1));
        return 8'h00;
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_ack(input int s);
        @(negedge clk); ack_valid = 1'b1; ack_src = 3'(s);
        @(negedge clk); ack_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 flags", rd_data, 8'h00);
        check("R1 req", {1'b0, req}, 8'h00);

        for (int v = 0; v < 256; v++) begin
            do_write(8'(v));
            check("R8 readback", rd_data, 8'(v));
            check("R2 req map", {1'b0, req}, {1'b0, exp_req(8'(v))});
        end

        do_write(8'h00);
        @(negedge clk); adc_done_evt = 1'b1; @(negedge clk); adc_done_evt = 1'b0;
        check("R4 first done", rd_data, 8'h10);
        do_write(8'h00);
        @(negedge clk); adc_done_evt = 1'b1; @(negedge clk); adc_done_evt = 1'b0;
        check("R4 second done", rd_data, 8'h10);
        @(negedge clk); t2_ovf_evt = 1'b1; @(negedge clk); t2_ovf_evt = 1'b0;
        check("R2 timer ovf", {1'b0, req}, 8'h0C);

        for (int s = 0; s < 8; s++) begin
            do_write(8'hFF);
            do_ack(s);
            check($sformatf("R7 R3 ack src %0d", s), rd_data, 8'hFF & ~ack_mask(s));
        end

        for (int j = 0; j < 3; j++) begin
            do_write(8'h00);
            @(negedge clk); pin_hi[j] = 1'b1; settle();
            check($sformatf("R5 rise %0d", j), rd_data, 8'(1 << (5 + j)));
            do_write(8'h00);
            @(negedge clk); pin_hi[j] = 1'b0; settle();
            check($sformatf("R5 fall %0d", j), rd_data, 8'h00);
            @(negedge clk); cmp_evt[j] = 1'b1; @(negedge clk); cmp_evt[j] = 1'b0;
            check($sformatf("R6 cmp low pin %0d", j), rd_data, 8'(1 << (5 + j)));
            @(negedge clk); pin_hi[j] = 1'b1; settle();
            do_write(8'h00);
            @(negedge clk); cmp_evt[j] = 1'b1; @(negedge clk); cmp_evt[j] = 1'b0;
            check($sformatf("R6 cmp high pin %0d", j), rd_data, 8'(1 << (5 + j)));
            @(negedge clk); pin_hi[j] = 1'b0; settle();
        end

        for (int i = 0; i < 2; i++) begin
            do_write(8'h00);
            @(negedge clk); pin_ext[i] = 1'b0; settle();
            check($sformatf("R10 fall %0d", i), rd_data, 8'(1 << i));
            do_ack(i);
            check($sformatf("R10 ack %0d", i), rd_data, 8'h00);
            @(negedge clk); pin_ext[i] = 1'b1; settle();
            check($sformatf("R10 rise %0d", i), rd_data, 8'h00);
        end

        @(negedge clk); mode_edge = 2'b10; settle();
        do_write(8'hFF);
        check("R9 write one ignored", rd_data, 8'hFE);
        @(negedge clk); pin_ext[0] = 1'b0; settle();
        check("R9 low level", rd_data, 8'hFF);
        check("R9 req0", {7'b0, req[0]}, 8'h01);
        do_write(8'h00);
        check("R9 write zero ignored", rd_data, 8'h01);
        do_ack(0);
        check("R9 ack ignored", rd_data, 8'h01);
        @(negedge clk); pin_ext[0] = 1'b1; settle();
        check("R9 high level", rd_data, 8'h00);
        @(negedge clk); mode_edge = 2'b11; settle();

        do_write(8'hFF);
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h00; adc_done_evt = 1'b1; cmp_evt[1] = 1'b1;
        @(negedge clk); wr_en = 1'b0; adc_done_evt = 1'b0; cmp_evt[1] = 1'b0;
        check("R11 set beats clear", rd_data, 8'h50);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule